// File: doc/BRIEF.md
# Compare-Match PWM Output Channel

This block is one output channel of a general-purpose timer. The timer's counter lives outside the channel. The channel receives the shared count value, a set of single-cycle strobes from the counter (period match, overflow, underflow, peak, valley and counter clear), and a level that tells whether the counter is running. It compares the count against its own compare value and drives a PWM pin from a one-bit level register.

Separate 2-bit action codes set what the level does in four cases: when the counter starts, when it stops, on a compare match and on a period match. A pending force request can pin the level low or high at the start of the next counting cycle. The compare value can be written directly. It can also be double-buffered: writes go to a shadow register, which is copied into the active compare register at a chosen point in the counting cycle.

A compare match also sets a sticky flag and, when enabled, sends out a one-cycle event pulse. Capture is not part of this channel.

Top module: `pwmch_top`

## Requirements
- R1: After reset the pin, the flag and the event are 0, the level register is 0, the active compare value is 0 and no force is pending.
- R2: On the first running cycle after a stopped cycle (start), the level takes the start action: 0 sets it low, 1 sets it high, and 2 or 3 keep it. Start overrides every other action in that cycle.
- R3: On the first stopped cycle after a running cycle (stop), the level takes the stop action, with the same codes as R2.
- R4: While running, a cycle with count equal to the active compare value is a compare match. It applies the compare action: 0 low, 1 high, 2 keep, 3 invert.
- R5: While running, a period-match strobe applies the period action, with the codes of R4. If a compare match and a period match fall in the same cycle, only the period action applies.
- R6: A force write with code 2 (low) or 3 (high) leaves a request pending. A force write with code 0 or 1 cancels any pending request. At the next running cycle start the pending level is applied, ahead of the period and compare actions, and the request is then dropped. A cycle start is an overflow or underflow strobe when the triangle-mode input is 0, and a valley strobe when it is 1.
- R7: With buffering on, a compare write goes to the buffer register. In sawtooth mode the buffer is copied into the active compare value on overflow, underflow or counter clear.
- R8: In triangle mode, with buffering on, the copy happens on a peak strobe when select bit 0 is set and on a valley strobe when select bit 1 is set. Overflow, underflow and clear do not copy in this mode.
- R9: The pin equals the level register ANDed with output-enable. While output-enable is 0 the pin is 0, but the level still follows every action.
- R10: The compare flag is set by a compare match and cleared by the flag-clear input. If both occur in the same cycle, the set wins.
- R11: The event output is a one-cycle pulse in the cycle after a compare match, provided event-enable was 1 in the cycle of the match.
- R12: With buffering off, a compare write takes effect directly on the active compare value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cnt | input | W | Shared counter value |
| run | input | 1 | Counter running state |
| perMatch | input | 1 | Period-match strobe |
| ovf | input | 1 | Overflow strobe |
| unf | input | 1 | Underflow strobe |
| peak | input | 1 | Triangle peak strobe |
| valley | input | 1 | Triangle valley strobe |
| cntClr | input | 1 | Counter-clear strobe |
| triMode | input | 1 | 1 = triangle counting, 0 = sawtooth |
| startAct | input | 2 | Action at counter start |
| stopAct | input | 2 | Action at counter stop |
| cmpAct | input | 2 | Action on compare match |
| perAct | input | 2 | Action on period match |
| outEn | input | 1 | Pin output enable |
| forceWr | input | 1 | Write strobe for the force request |
| forceCode | input | 2 | Force code: 2 low, 3 high, 0/1 cancel |
| bufEn | input | 1 | Compare double-buffering enable |
| bufSel | input | 2 | Triangle transfer select: bit0 peak, bit1 valley |
| wrEn | input | 1 | Compare value write strobe |
| wrData | input | W | Compare value to write |
| evtEn | input | 1 | Event pulse enable |
| flagClr | input | 1 | Clear the compare flag |
| pwmOut | output | 1 | PWM pin |
| cmpFlag | output | 1 | Sticky compare-match flag |
| cmpEvt | output | 1 | Compare-match event pulse |

## Verification
A wrong level register shows on the pin from the cycle after the mistaken action. If the wrong action is a keep or a later action that hides the error, it shows only at the next action that reads the current level. A stale or wrongly transferred compare value stays hidden until the count next equals either the expected or the actual value. Then it shows as a missing or extra level change, a flag that is set when it should not be, and an event pulse one cycle later. A force request that is lost or held too long shows only at a running cycle start. This is why the stimulus crosses force writes with frequent overflow, underflow and valley strobes.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

  typedef enum logic [1:0] {
    ACT_LOW  = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_KEEP = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic cycStart;
    logic perHit;
    logic cmpHit;
    logic xfer;
  } strobe_t;

  function automatic logic applyAct(input act_e a, input logic cur);
    case (a)
      ACT_LOW:  applyAct = 1'b0;
      ACT_HIGH: applyAct = 1'b1;
      ACT_KEEP: applyAct = cur;
      default:  applyAct = ~cur;
    endcase
  endfunction

endpackage

// File: rtl/pwmch_ctrl.sv
module pwmch_ctrl
  import pwmch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmpVal,
  input  logic         run,
  input  logic         perMatch,
  input  logic         ovf,
  input  logic         unf,
  input  logic         peak,
  input  logic         valley,
  input  logic         cntClr,
  input  logic         triMode,
  input  logic         bufEn,
  input  logic [1:0]   bufSel,
  output strobe_t      stb
);

  logic runD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runD <= 1'b0;
    else       runD <= run;
  end

  logic sawWrap;
  logic triXfer;

  always_comb begin
    sawWrap      = ovf | unf;
    triXfer      = (bufSel[0] & peak) | (bufSel[1] & valley);
    stb.startEv  = run & ~runD;
    stb.stopEv   = ~run & runD;
    stb.cycStart = run & (triMode ? valley : sawWrap);
    stb.perHit   = run & perMatch;
    stb.cmpHit   = run & (cnt == cmpVal);
    stb.xfer     = bufEn & (triMode ? triXfer : (sawWrap | cntClr));
  end

endmodule

// File: rtl/pwmch_data.sv
module pwmch_data
  import pwmch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      stb,
  input  logic [1:0]   startAct,
  input  logic [1:0]   stopAct,
  input  logic [1:0]   cmpAct,
  input  logic [1:0]   perAct,
  input  logic         forceWr,
  input  logic [1:0]   forceCode,
  input  logic         bufEn,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         evtEn,
  input  logic         flagClr,
  output logic [W-1:0] cmpVal,
  output logic         level,
  output logic         flag,
  output logic         evt
);

  logic [W-1:0] bufReg;
  logic [1:0]   pend;
  logic         nextLvl;

  // start and stop have no invert: code 3 keeps
  function automatic act_e edgeAct(input logic [1:0] c);
    edgeAct = (c == 2'd3) ? ACT_KEEP : act_e'(c);
  endfunction

  always_comb begin
    if (stb.startEv)                 nextLvl = applyAct(edgeAct(startAct), level);
    else if (stb.stopEv)             nextLvl = applyAct(edgeAct(stopAct), level);
    else if (stb.cycStart && pend[1]) nextLvl = pend[0];
    else if (stb.perHit)             nextLvl = applyAct(act_e'(perAct), level);
    else if (stb.cmpHit)             nextLvl = applyAct(act_e'(cmpAct), level);
    else                             nextLvl = level;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '0;
      bufReg <= '0;
      level  <= 1'b0;
      pend   <= 2'b00;
      flag   <= 1'b0;
      evt    <= 1'b0;
    end else begin
      level <= nextLvl;
      if (stb.xfer) cmpVal <= bufReg;
      if (wrEn) begin
        if (bufEn) bufReg <= wrData;
        else       cmpVal <= wrData;
      end
      if (forceWr)           pend <= forceCode[1] ? forceCode : 2'b00;
      else if (stb.cycStart) pend <= 2'b00;
      if (stb.cmpHit)    flag <= 1'b1;
      else if (flagClr)  flag <= 1'b0;
      evt <= stb.cmpHit & evtEn;
    end
  end

endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
  import pwmch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cnt,
  input  logic         run,
  input  logic         perMatch,
  input  logic         ovf,
  input  logic         unf,
  input  logic         peak,
  input  logic         valley,
  input  logic         cntClr,
  input  logic         triMode,
  input  logic [1:0]   startAct,
  input  logic [1:0]   stopAct,
  input  logic [1:0]   cmpAct,
  input  logic [1:0]   perAct,
  input  logic         outEn,
  input  logic         forceWr,
  input  logic [1:0]   forceCode,
  input  logic         bufEn,
  input  logic [1:0]   bufSel,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         evtEn,
  input  logic         flagClr,
  output logic         pwmOut,
  output logic         cmpFlag,
  output logic         cmpEvt
);

  strobe_t      stb;
  logic [W-1:0] cmpVal;
  logic         level;

  pwmch_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cnt(cnt), .cmpVal(cmpVal), .run(run),
    .perMatch(perMatch), .ovf(ovf), .unf(unf), .peak(peak), .valley(valley),
    .cntClr(cntClr), .triMode(triMode), .bufEn(bufEn), .bufSel(bufSel),
    .stb(stb)
  );

  pwmch_data #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .startAct(startAct), .stopAct(stopAct),
    .cmpAct(cmpAct), .perAct(perAct), .forceWr(forceWr), .forceCode(forceCode),
    .bufEn(bufEn), .wrEn(wrEn), .wrData(wrData), .evtEn(evtEn),
    .flagClr(flagClr), .cmpVal(cmpVal), .level(level), .flag(cmpFlag),
    .evt(cmpEvt)
  );

  assign pwmOut = outEn & level;

endmodule

// File: rtl/pwmch_chk.sv
module pwmch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       run,
  input logic       perMatch,
  input logic       ovf,
  input logic       unf,
  input logic       valley,
  input logic       triMode,
  input logic [1:0] startAct,
  input logic [1:0] stopAct,
  input logic [1:0] perAct,
  input logic       outEn,
  input logic       evtEn,
  input logic       pwmOut,
  input logic       cmpFlag,
  input logic       cmpEvt
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $rose(run) && startAct == 2'd1 |=> (pwmOut || !outEn));

  // R3
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $fell(run) && stopAct == 2'd0 |=> !pwmOut);

  // R5
  period_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && run && $past(run) && perMatch && perAct == 2'd0 &&
    !(triMode ? valley : (ovf | unf)) |=> !pwmOut);

  // R10
  flag_with_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvt |-> cmpFlag);

  // R11
  event_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && cmpEvt |-> $past(evtEn));

endmodule

bind pwmch_top pwmch_chk u_chk (
  .clk(clk), .rstN(rstN), .run(run), .perMatch(perMatch), .ovf(ovf),
  .unf(unf), .valley(valley), .triMode(triMode), .startAct(startAct),
  .stopAct(stopAct), .perAct(perAct), .outEn(outEn), .evtEn(evtEn),
  .pwmOut(pwmOut), .cmpFlag(cmpFlag), .cmpEvt(cmpEvt)
);

// File: tb/test_pwmch_top.sv
module test_pwmch_top;

  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] cnt, wrData;
  logic run, perMatch, ovf, unf, peak, valley, cntClr, triMode;
  logic [1:0] startAct, stopAct, cmpAct, perAct, forceCode, bufSel;
  logic outEn, forceWr, bufEn, wrEn, evtEn, flagClr;
  logic pwmOut, cmpFlag, cmpEvt;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string ctx = "R1";

  // bench model state
  logic [W-1:0] mCmp, mBuf;
  logic mLvl, mFlag, mEvt, mRunD;
  logic [1:0] mPend;
  string mTag = "R4";

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwmch_top #(.W(W)) i_pwmch_top (.*);

  function automatic logic act(input logic [1:0] c, input logic cur, input bit edgeKind);
    if (edgeKind && c == 2'd3) return cur;
    case (c)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return cur;
      default: return ~cur;
    endcase
  endfunction

  task automatic modelStep();
    logic hit, stEv, spEv, cs, ph, xf;
    hit  = run && cnt == mCmp;
    stEv = run && !mRunD;
    spEv = !run && mRunD;
    cs   = run && (triMode ? valley : (ovf | unf));
    ph   = run && perMatch;
    xf   = bufEn && (triMode ? ((bufSel[0] && peak) || (bufSel[1] && valley))
                             : (ovf | unf | cntClr));
    if (stEv)              begin mLvl = act(startAct, mLvl, 1); mTag = "R2"; end
    else if (spEv)         begin mLvl = act(stopAct, mLvl, 1);  mTag = "R3"; end
    else if (cs && mPend[1]) begin mLvl = mPend[0];             mTag = "R6"; end
    else if (ph)           begin mLvl = act(perAct, mLvl, 0);   mTag = "R5"; end
    else if (hit)          begin mLvl = act(cmpAct, mLvl, 0);   mTag = "R4"; end
    if (xf) mCmp = mBuf;
    if (wrEn) begin
      if (bufEn) mBuf = wrData;
      else       mCmp = wrData;
    end
    if (forceWr)  mPend = forceCode[1] ? forceCode : 2'b00;
    else if (cs)  mPend = 2'b00;
    if (hit)          mFlag = 1'b1;
    else if (flagClr) mFlag = 1'b0;
    mEvt  = hit && evtEn;
    mRunD = run;
  endtask

  task automatic chk(input string tag, input string what, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s ctx=%s %s actual=%0b expected=%0b", tag, ctx, what, a, e);
    end
  endtask

  task automatic checkAll();
    chk(outEn ? mTag : "R9", "pwmOut", pwmOut, outEn & mLvl);
    chk("R10", "cmpFlag", cmpFlag, mFlag);
    chk("R11", "cmpEvt", cmpEvt, mEvt);
  endtask

  task automatic idle();
    perMatch = 0; ovf = 0; unf = 0; peak = 0; valley = 0; cntClr = 0;
    forceWr = 0; wrEn = 0; flagClr = 0;
  endtask

  // one clock: inputs already set at negedge
  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
    cycles++;
    idle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog ctx=%s actual=running expected=finished", ctx);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; cnt = 0; run = 0; triMode = 0; wrData = 0;
    startAct = 2; stopAct = 2; cmpAct = 2; perAct = 2;
    forceCode = 0; bufSel = 0; outEn = 1; bufEn = 0; evtEn = 1;
    idle();
    mCmp = 0; mBuf = 0; mLvl = 0; mFlag = 0; mEvt = 0; mRunD = 0; mPend = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pwmOut", pwmOut, 1'b0);
    chk("R1", "cmpFlag", cmpFlag, 1'b0);
    chk("R1", "cmpEvt", cmpEvt, 1'b0);
    rstN = 1;

    // R1: compare resets to 0; start (keep) has priority in the first cycle
    ctx = "R1"; run = 1; cnt = 0; cmpAct = 1; cyc();
    cnt = 0; cyc();

    // R12: direct write; R5 priority over compare
    ctx = "R12"; wrEn = 1; wrData = 5; cnt = 1; cyc();
    ctx = "R5"; cnt = 5; perMatch = 1; perAct = 0; cyc();
    ctx = "R4"; cnt = 5; cmpAct = 3; cyc();
    cnt = 5; cyc();

    // R6: force high pending until overflow, then dropped
    ctx = "R6"; cmpAct = 2; perAct = 2; cnt = 1;
    forceWr = 1; forceCode = 3; cyc();
    repeat (3) begin cnt = 2; cyc(); end
    ovf = 1; cyc();
    perMatch = 1; perAct = 0; cyc();
    perAct = 2; unf = 1; cyc();
    forceWr = 1; forceCode = 2; cyc();
    forceWr = 1; forceCode = 1; cyc();
    ovf = 1; cyc();

    // R8: triangle transfer on peak only
    ctx = "R8"; triMode = 1; bufEn = 1; bufSel = 2'b01;
    perMatch = 1; perAct = 1; cyc();
    perAct = 2; wrEn = 1; wrData = 3; cmpAct = 0; cnt = 1; cyc();
    cnt = 3; cyc();
    valley = 1; ovf = 1; cnt = 4; cyc();
    cnt = 3; cyc();
    peak = 1; cnt = 4; cyc();
    cnt = 3; cyc();

    // R7: sawtooth transfer on counter clear
    ctx = "R7"; triMode = 0; perMatch = 1; perAct = 1; cyc();
    perAct = 2; wrEn = 1; wrData = 6; cnt = 1; cyc();
    cnt = 6; cyc();
    cntClr = 1; cnt = 0; cyc();
    cnt = 6; cyc();

    // R9: output gating keeps internal level
    ctx = "R9"; bufEn = 0; outEn = 0; perMatch = 1; perAct = 1; cyc();
    cnt = 2; cyc();
    outEn = 1; cnt = 2; cyc();

    // R3 / R2: stop and start actions
    ctx = "R3"; stopAct = 0; run = 0; cyc();
    ctx = "R2"; startAct = 1; run = 1; cyc();
    stopAct = 3; run = 0; cyc();
    startAct = 0; run = 1; cyc();

    // R10 / R11: flag clear and event enable
    ctx = "R10"; wrEn = 1; wrData = 9; cnt = 0; cyc();
    flagClr = 1; cnt = 1; cyc();
    cnt = 9; flagClr = 1; cyc();
    ctx = "R11"; evtEn = 0; cnt = 9; cyc();
    cnt = 1; cyc();

    // mixed random phase
    ctx = "RND";
    for (int i = 0; i < 4000; i++) begin
      if (i % 32 == 0) begin
        startAct = 2'($urandom); stopAct = 2'($urandom);
        cmpAct = 2'($urandom); perAct = 2'($urandom);
        bufEn = 1'($urandom); bufSel = 2'($urandom); evtEn = 1'($urandom);
      end
      if (i % 64 == 0) triMode = 1'($urandom);
      cnt      = W'($urandom % 8);
      if ($urandom % 16 == 0) run = ~run;
      perMatch = ($urandom % 6 == 0);
      ovf      = ($urandom % 8 == 0);
      unf      = ($urandom % 8 == 0);
      peak     = ($urandom % 8 == 0);
      valley   = ($urandom % 8 == 0);
      cntClr   = ($urandom % 8 == 0);
      outEn    = ($urandom % 8 != 0);
      forceWr  = ($urandom % 10 == 0);
      forceCode = 2'($urandom);
      wrEn     = ($urandom % 8 == 0);
      wrData   = W'($urandom % 8);
      flagClr  = ($urandom % 6 == 0);
      cyc();
    end
    finishRun();
  end

endmodule